// File: doc/BRIEF.md
# Power Domain and Module State Sequencer

This block sequences power-domain and per-module clock/reset state changes for a chip. Software writes a requested next state into each module's control word, then starts a transition for one or more domains with a one-hot go word. A module only takes on its requested state when a transition of its own domain completes. Module `m` belongs to domain `m % NUM_DOMAINS`. Module control words written with no go command leave the current state alone.

A domain that is powered off and asked to power up goes through a two-stage handshake. The go command raises a power-pending flag, which also drives an external power request pin. The transition then waits until software sets the power-stable acknowledge bit in that domain's control word. Each domain transition ends after a settle time of `SETTLE_CYC` cycles. The domain's busy bit then clears, and its done output pulses for one cycle.

Software reaches the block through a simple 32-bit register port with a one-cycle read latency. Module enable outputs follow the applied module states. The register layout, in byte offsets:

| Offset | Access | Content |
|---|---|---|
| 0x070 | read | bit d: domain d waits for external power |
| 0x120 | write | bit d: start a transition of domain d (reads 0) |
| 0x128 | read | bit d: domain d transition in progress |
| 0x200 + 4*d | read | bit 0: domain d powered |
| 0x300 + 4*d | read/write | bit 0: power wanted; bit 8: external power stable |
| 0x800 + 4*m | read | bits 4:0: current state of module m |
| 0xA00 + 4*m | read/write | bits 4:0: requested next state of module m |

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every domain reads powered (bit 0 of 0x200+4*d is 1), every module status and control word reads 2 (disabled), the busy word 0x128 and the pending word 0x070 read 0, and all of mod_en, ext_pwr_req and xfer_done are low.
- R2: A write to a module control word (0xA00+4*m) changes neither that module's status (0x800+4*m) nor mod_en until a go command for its domain completes.
- R3: A go command to a powered domain sets its bit in 0x128. Exactly SETTLE_CYC clock edges after the write edge, the bit clears. In the same cycle, every module m with m % NUM_DOMAINS equal to that domain takes its requested state, and the other modules are unchanged. mod_en[m] is 1 exactly when a module's status is 3.
- R4: Bit d of a word written to 0x120 starts domain d. Several bits set in one write start those domains together.
- R5: A go command to a domain that is already busy is ignored, and the transition in progress keeps its original completion cycle.
- R6: xfer_done[d] is high for exactly one cycle, in the cycle in which domain d's busy bit clears.
- R7: A go command to a powered domain whose control bit 0 is 0 turns the domain off when the transition completes, and its domain status bit 0 then reads 0.
- R8: A go command to an unpowered domain whose control bit 0 is 1 sets bit d of 0x070 and ext_pwr_req[d], and the domain stays busy until bit 8 of its control word is set. The pending flag clears one edge after the acknowledge write. The domain then reads powered, and the transition completes SETTLE_CYC edges after that.
- R9: Reads take effect one cycle after bus_rd. Reads of unmapped or unaligned offsets, of the go word, and of indices beyond the configured domains or modules return 0.
- R10: Module control and status words hold 5 bits (bits 4:0), and the upper bits read 0. A state other than 3 leaves mod_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| mod_en | output | NUM_MODULES | Module enabled (applied state is 3) |
| ext_pwr_req | output | NUM_DOMAINS | External power requested for a domain |
| xfer_done | output | NUM_DOMAINS | One-cycle pulse when a domain transition ends |

## Verification
If the settle counter loaded a wrong value, xfer_done and the mod_en change would move off the expected edge. A one-cycle error is therefore seen within SETTLE_CYC cycles of the go write. A wrong module-to-domain mapping changes a mod_en bit or status word of the other domain on the completion edge. The full sweep of patterns over both domains reads back every status word after each transition. A stuck power-pending state shows up on ext_pwr_req and on the busy word while software holds back the acknowledge. It also shows up as a completion that arrives before or long after the acknowledge write.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int OFF_PEND  = 'h070;
  localparam int OFF_GO    = 'h120;
  localparam int OFF_BUSY  = 'h128;
  localparam int OFF_DSTAT = 'h200;
  localparam int OFF_DCTL  = 'h300;
  localparam int OFF_MSTAT = 'h800;
  localparam int OFF_MCTL  = 'hA00;

  localparam int MST_W = 5;
  localparam logic [MST_W-1:0] MST_EN  = 5'd3;
  localparam logic [MST_W-1:0] MST_DIS = 5'd2;

  typedef enum logic [1:0] {
    DS_IDLE,
    DS_WAIT_PWR,
    DS_SETTLE
  } dseq_e;
endpackage

// File: rtl/psc_domain_seq.sv
module psc_domain_seq
  import psc_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic req_on,
  input  logic pwr_ack,
  output logic busy,
  output logic pending,
  output logic powered,
  output logic apply,
  output logic done
);
  dseq_e            st_q;
  logic [CNT_W-1:0] cnt_q;

  assign apply = (st_q == DS_SETTLE) && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= DS_IDLE;
      cnt_q   <= '0;
      busy    <= 1'b0;
      pending <= 1'b0;
      powered <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        DS_IDLE: begin
          if (go) begin
            busy <= 1'b1;
            if (!powered && req_on) begin
              st_q    <= DS_WAIT_PWR;
              pending <= 1'b1;
            end else begin
              st_q  <= DS_SETTLE;
              cnt_q <= CNT_W'(SETTLE_CYC);
            end
          end
        end
        DS_WAIT_PWR: begin
          if (pwr_ack) begin
            st_q    <= DS_SETTLE;
            cnt_q   <= CNT_W'(SETTLE_CYC);
            pending <= 1'b0;
            powered <= 1'b1;
          end
        end
        DS_SETTLE: begin
          if (apply) begin
            st_q    <= DS_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            powered <= req_on;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: st_q <= DS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psc_module_bank.sv
module psc_module_bank
  import psc_pkg::*;
#(
  parameter int NUM_DOMAINS = 2,
  parameter int NUM_MODULES = 8,
  localparam int MIDX_W = (NUM_MODULES > 1) ? $clog2(NUM_MODULES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_we,
  input  logic [MIDX_W-1:0]      ctl_idx,
  input  logic [MST_W-1:0]       ctl_wdata,
  input  logic [NUM_DOMAINS-1:0] apply,
  output logic [MST_W-1:0]       mctl  [NUM_MODULES],
  output logic [MST_W-1:0]       mstat [NUM_MODULES],
  output logic [NUM_MODULES-1:0] mod_en
);
  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
    localparam int DOM = m % NUM_DOMAINS;
    logic [MST_W-1:0] ctl_q;
    logic [MST_W-1:0] stat_q;
    logic             en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q  <= MST_DIS;
        stat_q <= MST_DIS;
        en_q   <= 1'b0;
      end else begin
        if (ctl_we && (ctl_idx == MIDX_W'(m))) begin
          ctl_q <= ctl_wdata;
        end
        if (apply[DOM]) begin
          stat_q <= ctl_q;
          en_q   <= (ctl_q == MST_EN);
        end
      end
    end

    assign mctl[m]   = ctl_q;
    assign mstat[m]  = stat_q;
    assign mod_en[m] = en_q;
  end
endmodule

// File: rtl/psc_bus_if.sv
module psc_bus_if
  import psc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_DOMAINS = 2,
  parameter int NUM_MODULES = 8,
  localparam int MIDX_W = (NUM_MODULES > 1) ? $clog2(NUM_MODULES) : 1,
  localparam int DIDX_W = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [NUM_DOMAINS-1:0] go,
  output logic [NUM_DOMAINS-1:0] req_on,
  output logic [NUM_DOMAINS-1:0] pwr_ack,
  output logic                   mctl_we,
  output logic [MIDX_W-1:0]      mctl_idx,
  output logic [MST_W-1:0]       mctl_wdata,
  input  logic [NUM_DOMAINS-1:0] busy,
  input  logic [NUM_DOMAINS-1:0] pending,
  input  logic [NUM_DOMAINS-1:0] powered,
  input  logic [MST_W-1:0]       mctl  [NUM_MODULES],
  input  logic [MST_W-1:0]       mstat [NUM_MODULES]
);
  logic              aligned;
  logic [ADDR_W-1:0] mctl_off, mstat_off, dctl_off, dstat_off;
  logic              mctl_hit, mstat_hit, dctl_hit, dstat_hit;
  logic [MIDX_W-1:0] mctl_ix, mstat_ix;
  logic [DIDX_W-1:0] dctl_ix, dstat_ix;
  logic [31:0]       rd_word;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign mctl_off  = bus_addr - ADDR_W'(OFF_MCTL);
  assign mstat_off = bus_addr - ADDR_W'(OFF_MSTAT);
  assign dctl_off  = bus_addr - ADDR_W'(OFF_DCTL);
  assign dstat_off = bus_addr - ADDR_W'(OFF_DSTAT);

  assign mctl_hit  = aligned && (bus_addr >= ADDR_W'(OFF_MCTL)) &&
                     ((mctl_off >> 2) < ADDR_W'(NUM_MODULES));
  assign mstat_hit = aligned && (bus_addr >= ADDR_W'(OFF_MSTAT)) &&
                     ((mstat_off >> 2) < ADDR_W'(NUM_MODULES));
  assign dctl_hit  = aligned && (bus_addr >= ADDR_W'(OFF_DCTL)) &&
                     ((dctl_off >> 2) < ADDR_W'(NUM_DOMAINS));
  assign dstat_hit = aligned && (bus_addr >= ADDR_W'(OFF_DSTAT)) &&
                     ((dstat_off >> 2) < ADDR_W'(NUM_DOMAINS));

  assign mctl_ix  = mctl_off[MIDX_W+1:2];
  assign mstat_ix = mstat_off[MIDX_W+1:2];
  assign dctl_ix  = dctl_off[DIDX_W+1:2];
  assign dstat_ix = dstat_off[DIDX_W+1:2];

  assign go = (bus_wr && (bus_addr == ADDR_W'(OFF_GO))) ?
              bus_wdata[NUM_DOMAINS-1:0] : '0;

  assign mctl_we    = bus_wr && mctl_hit;
  assign mctl_idx   = mctl_ix;
  assign mctl_wdata = bus_wdata[MST_W-1:0];

  // domain control words: bit 0 power wanted, bit 8 power stable
  always_ff @(posedge clk) begin
    if (rst) begin
      req_on  <= '1;
      pwr_ack <= '0;
    end else if (bus_wr && dctl_hit) begin
      for (int d = 0; d < NUM_DOMAINS; d++) begin
        if (dctl_ix == DIDX_W'(d)) begin
          req_on[d]  <= bus_wdata[0];
          pwr_ack[d] <= bus_wdata[8];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned && (bus_addr == ADDR_W'(OFF_PEND))) begin
      rd_word = 32'(pending);
    end else if (aligned && (bus_addr == ADDR_W'(OFF_BUSY))) begin
      rd_word = 32'(busy);
    end else if (dstat_hit) begin
      rd_word[0] = powered[dstat_ix];
    end else if (dctl_hit) begin
      rd_word[0] = req_on[dctl_ix];
      rd_word[8] = pwr_ack[dctl_ix];
    end else if (mstat_hit) begin
      rd_word = 32'(mstat[mstat_ix]);
    end else if (mctl_hit) begin
      rd_word = 32'(mctl[mctl_ix]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import psc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_DOMAINS = 2,
  parameter int NUM_MODULES = 8,
  parameter int SETTLE_CYC  = 4,
  localparam int MIDX_W = (NUM_MODULES > 1) ? $clog2(NUM_MODULES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [NUM_MODULES-1:0] mod_en,
  output logic [NUM_DOMAINS-1:0] ext_pwr_req,
  output logic [NUM_DOMAINS-1:0] xfer_done
);
  logic [NUM_DOMAINS-1:0] go_cmd, dom_req_on, dom_ack;
  logic [NUM_DOMAINS-1:0] dom_busy, dom_pend, dom_pwr, dom_apply, dom_done;
  logic                   mctl_we;
  logic [MIDX_W-1:0]      mctl_idx;
  logic [MST_W-1:0]       mctl_wdata;
  logic [MST_W-1:0]       mctl  [NUM_MODULES];
  logic [MST_W-1:0]       mstat [NUM_MODULES];

  psc_bus_if #(
    .ADDR_W(ADDR_W), .NUM_DOMAINS(NUM_DOMAINS), .NUM_MODULES(NUM_MODULES)
  ) bus_i (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .go(go_cmd), .req_on(dom_req_on), .pwr_ack(dom_ack),
    .mctl_we(mctl_we), .mctl_idx(mctl_idx), .mctl_wdata(mctl_wdata),
    .busy(dom_busy), .pending(dom_pend), .powered(dom_pwr),
    .mctl(mctl), .mstat(mstat)
  );

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    psc_domain_seq #(.SETTLE_CYC(SETTLE_CYC)) seq_i (
      .clk(clk), .rst(rst),
      .go(go_cmd[d]), .req_on(dom_req_on[d]), .pwr_ack(dom_ack[d]),
      .busy(dom_busy[d]), .pending(dom_pend[d]), .powered(dom_pwr[d]),
      .apply(dom_apply[d]), .done(dom_done[d])
    );
  end

  psc_module_bank #(
    .NUM_DOMAINS(NUM_DOMAINS), .NUM_MODULES(NUM_MODULES)
  ) bank_i (
    .clk(clk), .rst(rst),
    .ctl_we(mctl_we), .ctl_idx(mctl_idx), .ctl_wdata(mctl_wdata),
    .apply(dom_apply), .mctl(mctl), .mstat(mstat), .mod_en(mod_en)
  );

  assign ext_pwr_req = dom_pend;
  assign xfer_done   = dom_done;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int NUM_DOMAINS = 2,
  parameter int NUM_MODULES = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_DOMAINS-1:0] go,
  input logic [NUM_DOMAINS-1:0] busy,
  input logic [NUM_DOMAINS-1:0] pend,
  input logic [NUM_DOMAINS-1:0] powered,
  input logic [NUM_DOMAINS-1:0] apply,
  input logic [NUM_DOMAINS-1:0] done,
  input logic [NUM_MODULES-1:0] mod_en
);
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_d
    assert_pend_busy_R8: assert property (@(posedge clk) disable iff (rst)
      pend[d] |-> busy[d]);
    assert_pend_unpowered_R8: assert property (@(posedge clk) disable iff (rst)
      pend[d] |-> !powered[d]);
    assert_done_on_busy_fall_R6: assert property (@(posedge clk) disable iff (rst)
      done[d] |-> ($past(busy[d]) && !busy[d]));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
      done[d] |=> !done[d]);
    assert_start_needs_go_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(busy[d]) |-> $past(go[d]));
    assert_busy_go_ignored_R5: assert property (@(posedge clk) disable iff (rst)
      (busy[d] && go[d] && !apply[d]) |=> busy[d]);
  end

  assert_en_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(|apply) |=> $stable(mod_en));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
  .NUM_DOMAINS(NUM_DOMAINS), .NUM_MODULES(NUM_MODULES)
) chk_i (
  .clk(clk), .rst(rst), .go(go_cmd), .busy(dom_busy), .pend(dom_pend),
  .powered(dom_pwr), .apply(dom_apply), .done(dom_done), .mod_en(mod_en)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;
  localparam int AW  = 12;
  localparam int ND  = 2;
  localparam int NM  = 8;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NM-1:0] mod_en;
  logic [ND-1:0] ext_pwr_req, xfer_done;

  int checks = 0;
  int fails  = 0;
  logic [4:0] exp_stat [NM];
  logic [4:0] exp_ctl  [NM];

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.ADDR_W(AW), .NUM_DOMAINS(ND), .NUM_MODULES(NM), .SETTLE_CYC(LAT)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_en(mod_en),
    .ext_pwr_req(ext_pwr_req), .xfer_done(xfer_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the access happens on the next posedge
  task automatic wr(input int addr, input logic [31:0] data);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  function automatic logic [NM-1:0] exp_en();
    logic [NM-1:0] v;
    for (int m = 0; m < NM; m++) v[m] = (exp_stat[m] == 5'd3);
    return v;
  endfunction

  task automatic apply_model(input int d);
    for (int m = 0; m < NM; m++) if (m % ND == d) exp_stat[m] = exp_ctl[m];
  endtask

  task automatic check_all_status(input string tag);
    logic [31:0] v;
    for (int m = 0; m < NM; m++) begin
      rd('h800 + 4 * m, v);
      check(tag, v, 32'(exp_stat[m]));
    end
    check(tag, 32'(mod_en), 32'(exp_en()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [NM-1:0] old_en;
    for (int m = 0; m < NM; m++) begin exp_stat[m] = 5'd2; exp_ctl[m] = 5'd2; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 mod_en", 32'(mod_en), 0);
    check("R1 ext_pwr_req", 32'(ext_pwr_req), 0);
    check("R1 xfer_done", 32'(xfer_done), 0);
    rd('h128, v); check("R1 busy", v, 0);
    rd('h070, v); check("R1 pending", v, 0);
    for (int d = 0; d < ND; d++) begin
      rd('h200 + 4 * d, v); check("R1 domain on", v, 1);
    end
    for (int m = 0; m < NM; m++) begin
      rd('h800 + 4 * m, v); check("R1 module status", v, 2);
      rd('hA00 + 4 * m, v); check("R1 module control", v, 2);
    end

    // sweep of module patterns over both domains: R2, R3, R6
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < ND; d++) begin
        for (int m = 0; m < NM; m++) begin
          exp_ctl[m] = (((m + p + d) % 3) == 0) ? 5'd3 : 5'd2;
          wr('hA00 + 4 * m, 32'(exp_ctl[m]));
        end
        rd('h800 + 4 * d, v); check("R2 status unchanged by control write", v, 32'(exp_stat[d]));
        check("R2 mod_en unchanged by control write", 32'(mod_en), 32'(exp_en()));
        old_en = exp_en();
        wr('h120, 32'(1 << d));
        repeat (LAT - 1) @(negedge clk);
        check("R6 no early done", 32'(xfer_done), 0);
        check("R3 mod_en held during settle", 32'(mod_en), 32'(old_en));
        @(negedge clk);
        apply_model(d);
        check("R6 done pulse", 32'(xfer_done), 32'(1 << d));
        check("R3 mod_en at completion", 32'(mod_en), 32'(exp_en()));
        @(negedge clk);
        check("R6 done single cycle", 32'(xfer_done), 0);
        check_all_status("R3 module status after go");
      end
    end

    // R3 busy bit visible then cleared
    wr('h120, 32'h1);
    rd('h128, v); check("R3 busy set", v, 1);
    repeat (LAT) @(negedge clk);
    rd('h128, v); check("R3 busy cleared", v, 0);

    // R5 second go while busy ignored
    wr('h120, 32'h2);
    wr('h120, 32'h2);
    repeat (LAT - 2) @(negedge clk);
    check("R5 no done before original time", 32'(xfer_done), 0);
    @(negedge clk);
    check("R5 done at original time", 32'(xfer_done), 32'h2);
    repeat (3) @(negedge clk);
    check("R5 no second done", 32'(xfer_done), 0);

    // R4 two domains in one write
    for (int m = 0; m < NM; m++) begin
      exp_ctl[m] = (m < 4) ? 5'd3 : 5'd2;
      wr('hA00 + 4 * m, 32'(exp_ctl[m]));
    end
    wr('h120, 32'h3);
    repeat (LAT) @(negedge clk);
    apply_model(0); apply_model(1);
    check("R4 both domains done", 32'(xfer_done), 32'h3);
    check_all_status("R4 both domains applied");

    // R7 power down domain 1
    wr('h304, 32'h0);
    wr('h120, 32'h2);
    repeat (LAT) @(negedge clk);
    check("R7 done", 32'(xfer_done), 32'h2);
    rd('h204, v); check("R7 domain off", v, 0);
    rd('h200, v); check("R7 other domain on", v, 1);

    // R8 power-up handshake of domain 1
    for (int m = 0; m < NM; m++) begin
      exp_ctl[m] = (m % 2 == 1) ? 5'd3 : exp_ctl[m];
      wr('hA00 + 4 * m, 32'(exp_ctl[m]));
    end
    wr('h304, 32'h1);
    wr('h120, 32'h2);
    check("R8 power request", 32'(ext_pwr_req), 32'h2);
    repeat (10) @(negedge clk);
    check("R8 waits for ack", 32'(xfer_done), 0);
    rd('h070, v); check("R8 pending word", v, 2);
    rd('h128, v); check("R8 still busy", v, 2);
    rd('h204, v); check("R8 still off", v, 0);
    wr('h304, 32'h101);
    @(negedge clk);
    check("R8 request cleared after ack", 32'(ext_pwr_req), 0);
    repeat (LAT - 1) @(negedge clk);
    check("R8 no early done", 32'(xfer_done), 0);
    @(negedge clk);
    apply_model(1);
    check("R8 done after ack", 32'(xfer_done), 32'h2);
    rd('h204, v); check("R8 domain on", v, 1);
    rd('h304, v); check("R8 control readback", v, 32'h101);
    check_all_status("R8 modules applied");

    // R10 field width and non-enable state
    wr('hA00, 32'hFFFF_FFE5);
    rd('hA00, v); check("R10 control low bits", v, 5);
    exp_ctl[0] = 5'd5;
    wr('h120, 32'h1);
    repeat (LAT) @(negedge clk);
    apply_model(0);
    rd('h800, v); check("R10 status 5", v, 5);
    check("R10 mod_en low for state 5", 32'(mod_en[0]), 0);

    // R9 unmapped reads
    rd('h120, v); check("R9 go reads zero", v, 0);
    rd('h124, v); check("R9 unmapped", v, 0);
    rd('h208, v); check("R9 domain beyond range", v, 0);
    rd('h308, v); check("R9 domain control beyond range", v, 0);
    rd('h820, v); check("R9 module beyond range", v, 0);
    rd('h801, v); check("R9 unaligned", v, 0);
    rd('hA20, v); check("R9 control beyond range", v, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule